// File: doc/BRIEF.md
# Highway and Farm-Road Junction Light Controller

This block sequences the lamps at a junction where a heavily used highway crosses a farm road that rarely carries traffic. By default the highway shows green. A sensor reports a car waiting on the farm road. Only such a car can end the highway green, and only after a minimum green time has passed. The highway then goes to yellow. The farm road then gets green, which lasts while cars keep arriving but never longer than the long interval. After a yellow phase on the farm road, the highway returns to green.

The block contains its own interval timer, so it needs nothing outside it to run. The timer is cleared by a restart pulse that the controller issues on every phase change. From then on it raises a short-interval flag, used to time the yellow phases, and a long-interval flag, used to time the green phases. Both flags stay high until the next restart. A parameter selects how the phase register is encoded: as a dense two-bit code or as one-hot. The behaviour seen at the ports is the same for either choice.

Top module: `tlc_junction_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the highway lamp is green, the farm lamp is red and the restart output is 0.
- R2: Lamp codes are green=2'b00, yellow=2'b01 and red=2'b10. At no time are both lamps non-red.
- R3: From highway-green the controller moves to highway-yellow only in a cycle where the car input is 1 and the long flag is set. In every other case it stays in highway-green.
- R4: From highway-yellow it moves to farm-green in a cycle where the short flag is set. Otherwise it stays.
- R5: From farm-green it moves to farm-yellow in a cycle where the long flag is set or the car input is 0. Otherwise it stays.
- R6: From farm-yellow it moves back to highway-green in a cycle where the short flag is set. Otherwise it stays.
- R7: The restart output is 1 in exactly those cycles in which the controller changes phase. It is combinational, so it is high in the last cycle of the old phase.
- R8: The interval timer restarts from zero at the edge that ends a restart cycle. The short flag is high from SHORT_CNT cycles after that edge until the next restart. The long flag is high from LONG_CNT cycles after that edge until the next restart. Each yellow phase therefore lasts SHORT_CNT+1 cycles.
- R9: With a car present the whole time, highway green lasts LONG_CNT+1 cycles after reset. Farm green also lasts LONG_CNT+1 cycles when the car stays.
- R10: The dense encoding (ONE_HOT=0, codes HG=00, HY=01, FG=11, FY=10) and the one-hot encoding produce identical port behaviour for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| farm_car | input | 1 | A car is waiting on the farm road |
| hwy_lamp | output | 2 | Highway lamp code |
| farm_lamp | output | 2 | Farm-road lamp code |
| timer_restart | output | 1 | Clears the interval timer on a phase change |

## Verification
The assertions check, on every cycle, the rule that governs each phase and the link between restarts and phase changes. They also check that the timer flags clear on a restart, stay set until the next one, and rise in the right order, and that both roads never show a non-red lamp together. Some behaviour only the bench scenarios can show. This covers the exact dwell lengths of green and yellow, the effect of a car that appears and leaves before the minimum green expires, and the cycle-for-cycle agreement between the two state encodings under random traffic.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_HG = 2'd0,
    PH_HY = 2'd1,
    PH_FG = 2'd2,
    PH_FY = 2'd3
  } phase_e;

  localparam logic [1:0] LAMP_GREEN  = 2'b00;
  localparam logic [1:0] LAMP_YELLOW = 2'b01;
  localparam logic [1:0] LAMP_RED    = 2'b10;

  // Transition rule for one cycle.
  function automatic phase_e next_phase(phase_e cur, logic car, logic short_ok, logic long_ok);
    phase_e nxt;
    nxt = cur;
    case (cur)
      PH_HG: if (car && long_ok)   nxt = PH_HY;
      PH_HY: if (short_ok)         nxt = PH_FG;
      PH_FG: if (long_ok || !car)  nxt = PH_FY;
      PH_FY: if (short_ok)         nxt = PH_HG;
      default:                     nxt = PH_HG;
    endcase
    return nxt;
  endfunction

  function automatic logic [1:0] hwy_lamp_of(phase_e p);
    case (p)
      PH_HG:   return LAMP_GREEN;
      PH_HY:   return LAMP_YELLOW;
      default: return LAMP_RED;
    endcase
  endfunction

  function automatic logic [1:0] farm_lamp_of(phase_e p);
    case (p)
      PH_FG:   return LAMP_GREEN;
      PH_FY:   return LAMP_YELLOW;
      default: return LAMP_RED;
    endcase
  endfunction

  // Dense code: adjacent phases differ in one bit.
  function automatic logic [1:0] dense_encode(phase_e p);
    case (p)
      PH_HG:   return 2'b00;
      PH_HY:   return 2'b01;
      PH_FG:   return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic phase_e dense_decode(logic [1:0] c);
    case (c)
      2'b00:   return PH_HG;
      2'b01:   return PH_HY;
      2'b11:   return PH_FG;
      default: return PH_FY;
    endcase
  endfunction

  function automatic logic [3:0] onehot_encode(phase_e p);
    return 4'b0001 << p;
  endfunction

  // Any code that is not a legal one-hot value falls back to highway green.
  function automatic phase_e onehot_decode(logic [3:0] c);
    case (c)
      4'b0001: return PH_HG;
      4'b0010: return PH_HY;
      4'b0100: return PH_FG;
      4'b1000: return PH_FY;
      default: return PH_HG;
    endcase
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CNT = 3,
  parameter int LONG_CNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CNT + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_CNT);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_CNT);

  logic [CW-1:0] cnt_q;
  logic          cnt_at_cap;

  assign cnt_at_cap = (cnt_q == LONG_L);
  assign short_done = (cnt_q >= SHORT_L);
  assign long_done  = (cnt_q >= LONG_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (!cnt_at_cap) cnt_q <= cnt_q + 1'b1;
  end

  // A restart clears both flags at the next edge.
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!short_done && !long_done));
  // Flags hold as levels until the next restart.
  p_hold_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_done && !restart) |=> short_done);
  p_hold_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> long_done);
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);
endmodule

// File: rtl/tlc_phase_ctrl.sv
module tlc_phase_ctrl
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_e phase,
  output logic   restart
);
  phase_e phase_nxt;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [3:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= onehot_encode(PH_HG);
        else        st_q <= onehot_encode(phase_nxt);
      end
      assign phase = onehot_decode(st_q);
      p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1);
    end else begin : g_dense
      logic [1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= dense_encode(PH_HG);
        else        st_q <= dense_encode(phase_nxt);
      end
      assign phase = dense_decode(st_q);
    end
  endgenerate

  assign phase_nxt = next_phase(phase, car, short_done, long_done);
  assign restart   = (phase_nxt != phase);

  p_hg_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HG && !(car && long_done)) |=> phase == PH_HG);
  p_hg_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HG && car && long_done) |=> phase == PH_HY);
  p_hy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HY && short_done) |=> phase == PH_FG);
  p_fg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FG && (long_done || !car)) |=> phase == PH_FY);
  p_fy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FY && short_done) |=> phase == PH_HG);
  p_restart_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> phase != $past(phase));
  p_quiet_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(phase));
endmodule

// File: rtl/tlc_lamp_drive.sv
module tlc_lamp_drive
  import tlc_pkg::*;
(
  input  phase_e     phase,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);
  assign hwy_lamp  = hwy_lamp_of(phase);
  assign farm_lamp = farm_lamp_of(phase);
endmodule

// File: rtl/tlc_junction_ctrl.sv
module tlc_junction_ctrl
  import tlc_pkg::*;
#(
  parameter int SHORT_CNT = 3,
  parameter int LONG_CNT  = 8,
  parameter bit ONE_HOT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       farm_car,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp,
  output logic       timer_restart
);
  logic   short_done;
  logic   long_done;
  phase_e phase;

  tlc_interval_timer #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(timer_restart),
    .short_done(short_done), .long_done(long_done)
  );

  tlc_phase_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .car(farm_car),
    .short_done(short_done), .long_done(long_done),
    .phase(phase), .restart(timer_restart)
  );

  tlc_lamp_drive u_lamps (
    .phase(phase), .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  p_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp == LAMP_RED) || (farm_lamp == LAMP_RED));
  p_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));
endmodule

// File: tb/tb_tlc_junction_ctrl.sv
module tb_tlc_junction_ctrl;
  localparam int SHORT = 3;
  localparam int LONG  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic [1:0] hwy, farm, hwy_oh, farm_oh;
  logic rs, rs_oh;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int m_ph, m_cnt;
  logic [1:0] o_hwy;

  always #10 clk = ~clk;

  tlc_junction_ctrl #(.SHORT_CNT(SHORT), .LONG_CNT(LONG), .ONE_HOT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .farm_car(car),
    .hwy_lamp(hwy), .farm_lamp(farm), .timer_restart(rs));

  tlc_junction_ctrl #(.SHORT_CNT(SHORT), .LONG_CNT(LONG), .ONE_HOT(1'b1)) dut_oh (
    .clk(clk), .rst_n(rst_n), .farm_car(car),
    .hwy_lamp(hwy_oh), .farm_lamp(farm_oh), .timer_restart(rs_oh));

  // Bench reference: phases 0=HG 1=HY 2=FG 3=FY.
  function automatic int ref_next(int ph, bit c, int cnt);
    bit s, l;
    s = (cnt >= SHORT);
    l = (cnt >= LONG);
    case (ph)
      0: return (c && l) ? 1 : 0;
      1: return s ? 2 : 1;
      2: return (l || !c) ? 3 : 2;
      default: return s ? 0 : 3;
    endcase
  endfunction

  function automatic logic [1:0] ref_hwy(int ph);
    return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] ref_farm(int ph);
    return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check before the edge, advance the reference.
  task automatic step(bit c);
    int nph;
    string rtag;
    car = c;
    #1;
    nph = ref_next(m_ph, c, m_cnt);
    rtag = (m_ph == 0) ? "R3" : (m_ph == 1) ? "R4" : (m_ph == 2) ? "R5" : "R6";
    check(hwy == ref_hwy(m_ph), "R2 hwy", int'(hwy), int'(ref_hwy(m_ph)));
    check(farm == ref_farm(m_ph), "R2 farm", int'(farm), int'(ref_farm(m_ph)));
    check(rs == (nph != m_ph), {rtag, " R7 restart"}, int'(rs), int'(nph != m_ph));
    check({hwy_oh, farm_oh, rs_oh} == {hwy, farm, rs}, "R10 encodings",
          int'({hwy_oh, farm_oh, rs_oh}), int'({hwy, farm, rs}));
    o_hwy = hwy;
    if (nph != m_ph) m_cnt = 0;
    else if (m_cnt < LONG) m_cnt++;
    m_ph = nph;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    car = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(hwy == 2'b00, "R1 hwy", int'(hwy), 0);
      check(farm == 2'b10, "R1 farm", int'(farm), 2);
    end
    car = 1'b0;
    #1;
    check(rs == 1'b0, "R1 restart", int'(rs), 0);
    rst_n = 1'b1;
    m_ph = 0;
    m_cnt = 0;
  endtask

  initial begin
    int unsigned seed;
    int g, y, fg;
    bit left;
    seed = 32'd20240611;
    void'($urandom(seed));
    @(negedge clk);

    // Car present the whole time: dwell lengths.
    do_reset();
    check(hwy == 2'b00 && rs == 1'b0, "R1 after release", int'({hwy, rs}), 0);
    g = 0; y = 0; left = 1'b0;
    for (int i = 0; i < 2 * LONG + 2 * SHORT + 8; i++) begin
      step(1'b1);
      if (!left && o_hwy == 2'b00) g++;
      else begin
        left = 1'b1;
        if (o_hwy == 2'b01) y++;
      end
    end
    check(g == LONG + 1, "R9 hwy green dwell", g, LONG + 1);
    check(y == SHORT + 1, "R8 hwy yellow dwell", y, SHORT + 1);

    // Farm green held by car lasts the long interval.
    do_reset();
    fg = 0;
    for (int i = 0; i < 60; i++) begin
      step(1'b1);
      if (m_ph == 2 || (farm == 2'b00)) ;
    end
    do_reset();
    for (int i = 0; i < LONG + SHORT + 2; i++) step(1'b1);
    while (farm == 2'b00) begin
      fg++;
      step(1'b1);
    end
    check(fg == LONG + 1, "R9 farm green dwell", fg, LONG + 1);

    // Car arrives and leaves before minimum green: highway stays green (R3).
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1);
    g = 0;
    for (int i = 0; i < 30; i++) begin
      step(1'b0);
      if (o_hwy == 2'b00) g++;
    end
    check(g == 30, "R3 no car keeps highway green", g, 30);

    // Car leaves early in farm green: cut short (R5).
    do_reset();
    for (int i = 0; i < LONG + SHORT + 2; i++) step(1'b1);
    check(farm == 2'b00, "R5 in farm green", int'(farm), 0);
    step(1'b0);
    check(farm == 2'b01, "R5 early cut to yellow", int'(farm), 1);
    y = 0;
    while (farm == 2'b01) begin
      y++;
      step(1'b0);
    end
    check(y == SHORT + 1, "R8 farm yellow dwell", y, SHORT + 1);
    check(hwy == 2'b00, "R6 back to highway green", int'(hwy), 0);

    // Random traffic with bursts.
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if ((i / 200) % 3 == 2) step(($urandom % 16) == 0);
      else step(($urandom % 8) < 5);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule